// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable, cycle-level model of a 16-bit static memory with asynchronous-style controls. It has an active-low chip select, an active-low write strobe, an active-low read-drive enable and one active-low enable per 8-bit byte lane. Each clock cycle the control inputs are decoded into one of four modes: idle (deselected), read, outputs floated, or write. Each byte lane is stored, and driven or floated, on its own. The data bus is split into a data-in vector, a data-out vector and one drive-enable bit per lane, so no bidirectional pins are needed. A board-level wrapper can merge them into a real tri-state bus if it needs one.

A write does not commit while its window is still open. The window is the overlap of chip select low, write strobe low and at least one lane enable low. The block latches the address, data and lane selection on every clock while the window is open. It commits them on the clock edge that follows the cycle in which the window closes, whichever control closes it. The depth is set by an address-width parameter, so simulations stay small. The full-size part uses 19 address bits. Memory contents are not reset.

Top module: `sbl_sram_model`

## Requirements
- R1: While chip select (`csel_n_i`) is high, `lane_drv_o` is 2'b00 whatever the other controls are, and no write is committed.
- R2: While both lane enables are high (`lane_en_n_i` = 2'b11), `lane_drv_o` is 2'b00 and no write is committed, even with chip select and write strobe low.
- R3: In read mode (chip select low, write strobe high, read-drive enable low, at least one lane enabled), `lane_drv_o` equals `~lane_en_n_i`. For every driven lane, the matching byte of `rdata_o` holds the stored byte, and a floated lane reads as zero on `rdata_o`. Bit 0 of the enables and drive vectors belongs to data bits 7:0, and bit 1 belongs to bits 15:8.
- R4: With chip select low, write strobe high and read-drive enable high, `lane_drv_o` is 2'b00.
- R5: While chip select and write strobe are both low, `lane_drv_o` is 2'b00 whatever the read-drive enable is, and that enable does not affect what is written.
- R6: A write stores bits 7:0 only when `lane_en_n_i[0]` is low and bits 15:8 only when `lane_en_n_i[1]` is low. A lane that is not selected keeps its old content.
- R7: A write commits once, at the clock edge after the first cycle in which its window is closed. It uses the address, data and lane selection sampled in the last cycle the window was open, and it behaves the same whether the write strobe, chip select or the lane enables close it.
- R8: A read of the address whose write is committing in the same cycle returns the new bytes for the lanes that write selects, and the old bytes for the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_n_i | input | 1 | Active-low reset of the write-window state |
| csel_n_i | input | 1 | Active-low chip select |
| wstb_n_i | input | 1 | Active-low write strobe |
| rden_n_i | input | 1 | Active-low read-drive enable |
| lane_en_n_i | input | 2 | Active-low byte-lane enables (bit 0: bits 7:0) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero on floated lanes |
| lane_drv_o | output | 2 | Per-lane output-drive enable |

## Verification
The two functions that can fall in the same cycle are the commit of a closing write and a read of that same address. The bench provokes this by raising only the write strobe right after a one-cycle window, and issuing a full-word read of the address just written in that same cycle. It does this once with both lanes written and once with only the upper lane written. The read data is sampled before the commit edge and judged against the new bytes in the selected lanes and the old bytes in the others.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_FLOAT = 2'd2,
    MODE_WRITE = 2'd3
  } sbl_mode_e;

  // Priority: deselect, then write, then read/float.
  function automatic sbl_mode_e decode_mode(input logic csel_n, input logic wstb_n,
                                            input logic rden_n, input logic no_lane);
    sbl_mode_e m;
    if (csel_n || no_lane)  m = MODE_IDLE;
    else if (!wstb_n)       m = MODE_WRITE;
    else if (!rden_n)       m = MODE_READ;
    else                    m = MODE_FLOAT;
    return m;
  endfunction

  function automatic logic window_open(input sbl_mode_e m);
    return (m == MODE_WRITE);
  endfunction

endpackage

// File: rtl/sbl_mode_decode.sv
module sbl_mode_decode
  import sbl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             csel_n_i,
  input  logic             wstb_n_i,
  input  logic             rden_n_i,
  input  logic [LANES-1:0] lane_en_n_i,
  output sbl_mode_e        mode_o,
  output logic             win_o,
  output logic [LANES-1:0] lane_drv_o
);

  logic no_lane;
  assign no_lane = &lane_en_n_i;

  always_comb begin
    mode_o = decode_mode(csel_n_i, wstb_n_i, rden_n_i, no_lane);
    win_o  = window_open(mode_o);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_drv
    assign lane_drv_o[l] = (mode_o == MODE_READ) && !lane_en_n_i[l];
  end

endmodule

// File: rtl/sbl_wr_window.sv
module sbl_wr_window #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              win_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  lane_en_n_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic [LANES-1:0]  lanes_q_o
);

  logic open_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) open_q <= 1'b0;
    else          open_q <= win_i;
  end

  // Last sample taken while the window is open wins.
  always_ff @(posedge clk_i) begin
    if (win_i) begin
      addr_q_o  <= addr_i;
      data_q_o  <= wdata_i;
      lanes_q_o <= ~lane_en_n_i;
    end
  end

  assign commit_o = open_q && !win_i;

  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    commit_o |=> !commit_o); // R7

  AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    commit_o |-> $past(win_i)); // R7

endmodule

// File: rtl/sbl_lane.sv
module sbl_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              commit_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              drive_i,
  output logic [LANE_W-1:0] rd_data_o
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic              do_wr;
  logic              hit;
  logic [LANE_W-1:0] raw;

  assign do_wr = commit_i && sel_i;
  assign hit   = do_wr && (rd_addr_i == wr_addr_i);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wr_addr_i] <= wr_data_i;
  end

  assign raw       = hit ? wr_data_i : mem[rd_addr_i];
  assign rd_data_o = drive_i ? raw : '0;

endmodule

// File: rtl/sbl_sram_model.sv
module sbl_sram_model
  import sbl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              csel_n_i,
  input  logic              wstb_n_i,
  input  logic              rden_n_i,
  input  logic [LANES-1:0]  lane_en_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  lane_drv_o
);

  sbl_mode_e         mode;
  logic              win;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [LANES-1:0]  wr_lanes;

  sbl_mode_decode #(.LANES(LANES)) u_dec (
    .csel_n_i    (csel_n_i),
    .wstb_n_i    (wstb_n_i),
    .rden_n_i    (rden_n_i),
    .lane_en_n_i (lane_en_n_i),
    .mode_o      (mode),
    .win_o       (win),
    .lane_drv_o  (lane_drv_o)
  );

  sbl_wr_window #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_win (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .win_i       (win),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .lane_en_n_i (lane_en_n_i),
    .commit_o    (commit),
    .addr_q_o    (wr_addr),
    .data_q_o    (wr_data),
    .lanes_q_o   (wr_lanes)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbl_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i     (clk_i),
      .commit_i  (commit),
      .sel_i     (wr_lanes[l]),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data[l*LANE_W +: LANE_W]),
      .rd_addr_i (addr_i),
      .drive_i   (lane_drv_o[l]),
      .rd_data_o (rdata_o[l*LANE_W +: LANE_W])
    );
  end

  AST_DESEL_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    csel_n_i |-> (lane_drv_o == '0)); // R1

  AST_NO_LANE_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (&lane_en_n_i) |-> (lane_drv_o == '0)); // R2

  AST_READ_LANES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!csel_n_i && wstb_n_i && !rden_n_i) |-> (lane_drv_o == ~lane_en_n_i)); // R3

  AST_OUT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!csel_n_i && wstb_n_i && rden_n_i) |-> (lane_drv_o == '0)); // R4

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!csel_n_i && !wstb_n_i) |-> (lane_drv_o == '0)); // R5

  AST_DESEL_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (csel_n_i && $past(csel_n_i)) |-> !commit); // R1

endmodule

// File: tb/sbl_sram_model_tb.sv
`timescale 1ns/1ps
module sbl_sram_model_tb_top;

  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          csel_n, wstb_n, rden_n;
  logic [1:0]    len_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [1:0]    drv;

  logic [15:0] shadow [N];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  sbl_sram_model #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .csel_n_i(csel_n), .wstb_n_i(wstb_n),
    .rden_n_i(rden_n), .lane_en_n_i(len_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .lane_drv_o(drv)
  );

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h1357) ^ 16'hA5C3 ^ (k * 16'h0F0F));
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] ln_n);
    return {{8{~ln_n[1]}}, {8{~ln_n[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic o, input logic [1:0] l,
                     input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    csel_n = c; wstb_n = w; rden_n = o; len_n = l; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
  endtask

  // how: 0 strobe ends, 1 chip select ends, 2 lane enables end
  task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] l,
                          input int how, input logic o);
    cyc(1'b0, 1'b0, o, l, AW'(a), d);
    chk(drv == 2'b00, "R5 no drive in write", 32'(drv), 32'h0);
    case (how)
      0:       cyc(1'b0, 1'b1, 1'b1, l, AW'(a), ~d);
      1:       cyc(1'b1, 1'b0, 1'b1, l, AW'(a), ~d);
      default: cyc(1'b0, 1'b0, 1'b1, 2'b11, AW'(a), ~d);
    endcase
    shadow[a] = (shadow[a] & ~lane_mask(l)) | (d & lane_mask(l));
    idle();
  endtask

  task automatic rd_chk(input int a, input logic [1:0] l, input string req);
    cyc(1'b0, 1'b1, 1'b0, l, AW'(a), 16'h5A5A);
    if (l == 2'b11) begin
      chk(drv == 2'b00, req, 32'(drv), 32'h0);
    end else begin
      chk(drv == ~l && rdata == (shadow[a] & lane_mask(l)), req,
          {14'b0, drv, rdata}, {14'b0, ~l, shadow[a] & lane_mask(l)});
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    csel_n = 1'b1; wstb_n = 1'b1; rden_n = 1'b1; len_n = 2'b11; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(drv == 2'b00 && rdata == 16'h0, "reset state R1", {14'b0, drv, rdata}, 32'h0);
    rst_n = 1'b1;
    idle();

    // Fill every location, rotating the way each window ends (R7)
    for (int a = 0; a < N; a++) do_write(a, pat(a, 0), 2'b00, a % 3, a[0]);
    for (int a = 0; a < N; a++)
      for (int l = 0; l < 4; l++) rd_chk(a, 2'(l), "R3 read lanes / R2 no lane");

    // Single-lane writes: R6
    for (int a = 0; a < N; a++) begin
      do_write(a, pat(a, 1), (a[1] ? 2'b01 : 2'b10), a % 3, 1'b0);
      rd_chk(a, 2'b00, "R6 lane select");
    end

    // Output disabled: R4
    for (int l = 0; l < 4; l++) begin
      cyc(1'b0, 1'b1, 1'b1, 2'(l), AW'(l), '0);
      chk(drv == 2'b00, "R4 output disabled", 32'(drv), 32'h0);
    end

    // Deselect sweep with write attempts: R1
    for (int v = 0; v < 16; v++) begin
      cyc(1'b1, v[0], v[1], v[3:2], AW'(v), ~pat(v, 2));
      chk(drv == 2'b00, "R1 deselect float", 32'(drv), 32'h0);
    end
    idle();
    for (int a = 0; a < N; a++) rd_chk(a, 2'b00, "R1 no write while deselected");

    // Both lanes off with chip select and strobe low: R2
    for (int a = 0; a < N; a++) begin
      cyc(1'b0, 1'b0, a[0], 2'b11, AW'(a), ~shadow[a]);
      chk(drv == 2'b00, "R2 no lane float", 32'(drv), 32'h0);
    end
    idle();
    for (int a = 0; a < N; a++) rd_chk(a, 2'b00, "R2 no write without lanes");

    // Multi-cycle window, last sample wins: R7
    cyc(1'b0, 1'b0, 1'b1, 2'b00, AW'(3), 16'h1111);
    cyc(1'b0, 1'b0, 1'b0, 2'b00, AW'(5), 16'h2222);
    cyc(1'b0, 1'b0, 1'b1, 2'b10, AW'(5), 16'h3333);
    cyc(1'b0, 1'b1, 1'b1, 2'b10, AW'(5), 16'h0000);
    shadow[5] = {shadow[5][15:8], 8'h33};
    idle();
    rd_chk(3, 2'b00, "R7 earlier sample not stored");
    rd_chk(5, 2'b00, "R7 last sample stored");

    // Same-cycle commit and read: R8
    cyc(1'b0, 1'b0, 1'b1, 2'b00, AW'(7), 16'hBEEF);
    cyc(1'b0, 1'b1, 1'b0, 2'b00, AW'(7), 16'h0000);
    chk(rdata == 16'hBEEF && drv == 2'b11, "R8 bypass full", {14'b0, drv, rdata},
        {14'b0, 2'b11, 16'hBEEF});
    shadow[7] = 16'hBEEF;
    cyc(1'b0, 1'b0, 1'b1, 2'b01, AW'(9), 16'hC0DE);
    cyc(1'b0, 1'b1, 1'b0, 2'b00, AW'(9), 16'h0000);
    chk(rdata == {8'hC0, shadow[9][7:0]}, "R8 bypass upper lane", 32'(rdata),
        32'({8'hC0, shadow[9][7:0]}));
    shadow[9] = {8'hC0, shadow[9][7:0]};
    idle();
    rd_chk(7, 2'b00, "R8 committed full");
    rd_chk(9, 2'b00, "R8 committed upper");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule